// File: doc/BRIEF.md
# Sample-Sum-Reset Phase Sequencer

This block produces the digital control phases for a switched-capacitor delay-and-sum array. The array has a number of input channels. Each channel has a sampling strobe that drives its own capacitor. The strobe can be shifted by a programmable number of fast-clock ticks, so that each channel is captured at the instant its wavefront arrives. When the last channel's strobe has ended, the block waits for a guard interval and then raises a summation strobe. It then waits for a second guard interval and raises a reset strobe, which clears the summer before the next frame.

A frame starts on a request pulse. The per-channel delay codes are captured on that same edge, and the frame uses the captured values throughout. Changes to the codes after that edge have no effect on the frame in progress. A busy flag stays high for the whole frame. Requests that arrive while the flag is high are dropped.

Top module: `sample_sum_sequencer`

## Requirements
- R1: After a synchronous reset, all sample strobes, `sum_stb`, `clr_stb` and `busy` are low.
- R2: When the block is idle and `frame_req` is high at a rising edge, a frame starts. `busy` goes high from the next cycle and stays high throughout the frame. Every strobe is asserted only while `busy` is high.
- R3: Let t = 0 be the first cycle after the accepting edge. The sample strobe of channel i is high exactly in cycles t = d_i to t = d_i + SAMP_LEN - 1. Here d_i is the unsigned code in `dly_codes[i*CODE_W +: CODE_W]`. The spacing between the strobes of two channels therefore equals the difference of their codes.
- R4: The codes are captured at the accepting edge. Later changes on `dly_codes` have no effect on the frame in progress.
- R5: Let E = max(d_i) + SAMP_LEN. `sum_stb` is high exactly in cycles E + GUARD to E + GUARD + SUM_LEN - 1. No sample strobe is high in those cycles.
- R6: `clr_stb` is high exactly in cycles E + 2*GUARD + SUM_LEN to E + 2*GUARD + SUM_LEN + RST_LEN - 1. `clr_stb` is never high in the same cycle as `sum_stb`.
- R7: `busy` falls in the cycle after the reset phase ends. A `frame_req` seen while `busy` is high neither restarts nor extends the frame.
- R8: During the two guard intervals, every strobe is low. GUARD is at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_req | input | 1 | Frame start request |
| dly_codes | input | N_CH*CODE_W | Per-channel delay codes; channel i at bits [i*CODE_W +: CODE_W] |
| samp_stb | output | N_CH | Per-channel sampling strobes |
| sum_stb | output | 1 | Summation phase strobe |
| clr_stb | output | 1 | Summer reset phase strobe |
| busy | output | 1 | Frame in progress |

## Verification
The hardest situation to reach from the ports is a frame whose timing is disturbed while it is already running. This happens when requests arrive in the middle of a frame and the code inputs change after capture, including in the last cycle of the reset phase. The bench sweeps every combination of codes for a four-channel, three-bit configuration and runs the frames back to back. On every third frame it drives random requests and random codes on each cycle up to the return to idle. It compares all outputs against a trace computed from the captured codes.

// File: rtl/phseq_pkg.sv
package phseq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SAMP  = 3'd1,
        PH_GAP_A = 3'd2,
        PH_SUM   = 3'd3,
        PH_GAP_B = 3'd4,
        PH_CLR   = 3'd5
    } phase_e;

    // successor of a timed phase once its length has elapsed
    function automatic phase_e phase_after(input phase_e p);
        case (p)
            PH_SAMP:  return PH_GAP_A;
            PH_GAP_A: return PH_SUM;
            PH_SUM:   return PH_GAP_B;
            PH_GAP_B: return PH_CLR;
            default:  return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/code_latch.sv
module code_latch #(
    parameter int N_CH   = 4,
    parameter int CODE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [N_CH*CODE_W-1:0]   codes_in,
    output logic [N_CH*CODE_W-1:0]   codes_q,
    output logic [CODE_W-1:0]        span_max
);

    always_ff @(posedge clk) begin
        if (rst)
            codes_q <= '0;
        else if (load)
            codes_q <= codes_in;
    end

    // largest captured code sets the end of the sampling window
    always_comb begin
        span_max = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (codes_q[i*CODE_W +: CODE_W] > span_max)
                span_max = codes_q[i*CODE_W +: CODE_W];
        end
    end

endmodule

// File: rtl/strobe_gen.sv
module strobe_gen #(
    parameter int CODE_W   = 4,
    parameter int TMR_W    = 5,
    parameter int SAMP_LEN = 2
) (
    input  logic              active,
    input  logic [TMR_W-1:0]  tmr,
    input  logic [CODE_W-1:0] code,
    output logic              stb
);

    logic [TMR_W-1:0] t_open;
    logic [TMR_W-1:0] t_close;

    assign t_open  = TMR_W'(code);
    assign t_close = TMR_W'(code) + TMR_W'(SAMP_LEN);
    assign stb     = active && (tmr >= t_open) && (tmr < t_close);

endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
    import phseq_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int TMR_W    = 5,
    parameter int SAMP_LEN = 2,
    parameter int GUARD    = 1,
    parameter int SUM_LEN  = 2,
    parameter int RST_LEN  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_req,
    input  logic [CODE_W-1:0] span_max,
    output logic              load,
    output phase_e            phase,
    output logic [TMR_W-1:0]  tmr
);

    logic [TMR_W-1:0] last_tick;

    assign load = (phase == PH_IDLE) && frame_req;

    always_comb begin
        case (phase)
            PH_SAMP:            last_tick = TMR_W'(span_max) + TMR_W'(SAMP_LEN - 1);
            PH_GAP_A, PH_GAP_B: last_tick = TMR_W'(GUARD - 1);
            PH_SUM:             last_tick = TMR_W'(SUM_LEN - 1);
            PH_CLR:             last_tick = TMR_W'(RST_LEN - 1);
            default:            last_tick = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            tmr   <= '0;
        end else if (phase == PH_IDLE) begin
            tmr <= '0;
            if (frame_req)
                phase <= PH_SAMP;
        end else if (tmr == last_tick) begin
            phase <= phase_after(phase);
            tmr   <= '0;
        end else begin
            tmr <= tmr + 1'b1;
        end
    end

endmodule

// File: rtl/sample_sum_sequencer.sv
module sample_sum_sequencer
    import phseq_pkg::*;
#(
    parameter int N_CH     = 4,
    parameter int CODE_W   = 4,
    parameter int SAMP_LEN = 2,
    parameter int GUARD    = 1,
    parameter int SUM_LEN  = 2,
    parameter int RST_LEN  = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   frame_req,
    input  logic [N_CH*CODE_W-1:0] dly_codes,
    output logic [N_CH-1:0]        samp_stb,
    output logic                   sum_stb,
    output logic                   clr_stb,
    output logic                   busy
);

    localparam int TMR_W = $clog2((1 << CODE_W) + SAMP_LEN + SUM_LEN + RST_LEN + GUARD + 1);

    logic                   load;
    phase_e                 phase;
    logic [TMR_W-1:0]       tmr;
    logic [N_CH*CODE_W-1:0] codes_q;
    logic [CODE_W-1:0]      span_max;

    code_latch #(.N_CH(N_CH), .CODE_W(CODE_W)) i_latch (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .codes_in (dly_codes),
        .codes_q  (codes_q),
        .span_max (span_max)
    );

    phase_fsm #(
        .CODE_W(CODE_W), .TMR_W(TMR_W), .SAMP_LEN(SAMP_LEN),
        .GUARD(GUARD), .SUM_LEN(SUM_LEN), .RST_LEN(RST_LEN)
    ) i_fsm (
        .clk       (clk),
        .rst       (rst),
        .frame_req (frame_req),
        .span_max  (span_max),
        .load      (load),
        .phase     (phase),
        .tmr       (tmr)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        strobe_gen #(.CODE_W(CODE_W), .TMR_W(TMR_W), .SAMP_LEN(SAMP_LEN)) i_stb (
            .active (phase == PH_SAMP),
            .tmr    (tmr),
            .code   (codes_q[g*CODE_W +: CODE_W]),
            .stb    (samp_stb[g])
        );
    end

    assign sum_stb = (phase == PH_SUM);
    assign clr_stb = (phase == PH_CLR);
    assign busy    = (phase != PH_IDLE);

endmodule

// File: rtl/sample_sum_chk.sv
module sample_sum_chk #(
    parameter int N_CH   = 4,
    parameter int CODE_W = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   frame_req,
    input logic [N_CH-1:0]        samp_stb,
    input logic                   sum_stb,
    input logic                   clr_stb,
    input logic                   busy,
    input logic [N_CH*CODE_W-1:0] lat_codes
);

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && frame_req) |=> busy);

    p_strobe_in_frame_r2: assert property (@(posedge clk) disable iff (rst)
        ((|samp_stb) || sum_stb || clr_stb) |-> busy);

    p_codes_held_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(lat_codes));

    p_sum_clean_r5: assert property (@(posedge clk) disable iff (rst)
        sum_stb |-> (samp_stb == '0));

    p_sum_clr_apart_r6: assert property (@(posedge clk) disable iff (rst)
        !(sum_stb && clr_stb));

    p_guard_after_sum_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(sum_stb) |-> (!clr_stb && samp_stb == '0));

    p_guard_before_sum_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(sum_stb) |-> ($past(samp_stb) == '0));

    p_hold_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !clr_stb) |=> busy);

endmodule

bind sample_sum_sequencer sample_sum_chk #(.N_CH(N_CH), .CODE_W(CODE_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_req (frame_req),
    .samp_stb  (samp_stb),
    .sum_stb   (sum_stb),
    .clr_stb   (clr_stb),
    .busy      (busy),
    .lat_codes (codes_q)
);

// File: tb/test_sample_sum_sequencer.sv
module test_sample_sum_sequencer;

    localparam int N  = 4;
    localparam int W  = 3;
    localparam int SL = 2;
    localparam int G  = 1;
    localparam int SU = 2;
    localparam int RL = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           frame_req = 1'b0;
    logic [N*W-1:0] dly_codes = '0;
    logic [N-1:0]   samp_stb;
    logic           sum_stb;
    logic           clr_stb;
    logic           busy;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    sample_sum_sequencer #(
        .N_CH(N), .CODE_W(W), .SAMP_LEN(SL), .GUARD(G), .SUM_LEN(SU), .RST_LEN(RL)
    ) i_sample_sum_sequencer (
        .clk(clk), .rst(rst), .frame_req(frame_req), .dly_codes(dly_codes),
        .samp_stb(samp_stb), .sum_stb(sum_stb), .clr_stb(clr_stb), .busy(busy)
    );

    // one frame: codes from 'code', compared cycle by cycle against the arithmetic trace
    task automatic run_frame(input int code, input bit noisy);
        int d[N];
        int dmax, e, s0, c0, len;
        bit bad;
        dmax = 0;
        for (int i = 0; i < N; i++) begin
            d[i] = (code >> (W*i)) & ((1 << W) - 1);
            if (d[i] > dmax) dmax = d[i];
        end
        e   = dmax + SL;
        s0  = e + G;
        c0  = s0 + SU + G;
        len = c0 + RL;
        dly_codes = (N*W)'(code);
        frame_req = 1'b1;
        @(negedge clk);
        bad = 1'b0;
        n_vec++;
        for (int t = 0; t <= len; t++) begin
            logic [N-1:0] es;
            logic esum, eclr, ebusy;
            for (int i = 0; i < N; i++) es[i] = (t >= d[i]) && (t < d[i] + SL);
            esum  = (t >= s0) && (t < s0 + SU);
            eclr  = (t >= c0) && (t < c0 + RL);
            ebusy = (t < len);
            if (!bad) begin
                if (samp_stb !== es) begin
                    bad = 1'b1;
                    if (t >= e)
                        $display("FAIL R8 code=%0h t=%0d samp actual=%b expected=%b", code, t, samp_stb, es);
                    else if (noisy)
                        $display("FAIL R4 code=%0h t=%0d samp actual=%b expected=%b", code, t, samp_stb, es);
                    else
                        $display("FAIL R3 code=%0h t=%0d samp actual=%b expected=%b", code, t, samp_stb, es);
                end else if (sum_stb !== esum) begin
                    bad = 1'b1;
                    $display("FAIL R5 code=%0h t=%0d sum actual=%b expected=%b", code, t, sum_stb, esum);
                end else if (clr_stb !== eclr) begin
                    bad = 1'b1;
                    $display("FAIL R6 code=%0h t=%0d clr actual=%b expected=%b", code, t, clr_stb, eclr);
                end else if (busy !== ebusy) begin
                    bad = 1'b1;
                    if (noisy)
                        $display("FAIL R7 code=%0h t=%0d busy actual=%b expected=%b", code, t, busy, ebusy);
                    else
                        $display("FAIL R2 code=%0h t=%0d busy actual=%b expected=%b", code, t, busy, ebusy);
                end
            end
            if (t < len) begin
                if (noisy) begin
                    frame_req = 1'($urandom);
                    dly_codes = (N*W)'($urandom);
                end else begin
                    frame_req = 1'b0;
                end
                @(negedge clk);
            end
        end
        if (bad) n_fail++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        n_vec++;
        if (samp_stb !== '0 || sum_stb !== 1'b0 || clr_stb !== 1'b0 || busy !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 in reset actual=%b%b%b%b expected=0", samp_stb, sum_stb, clr_stb, busy);
        end
        rst = 1'b0;
        @(negedge clk);
        n_vec++;
        if (samp_stb !== '0 || sum_stb !== 1'b0 || clr_stb !== 1'b0 || busy !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 after reset actual=%b%b%b%b expected=0", samp_stb, sum_stb, clr_stb, busy);
        end
        // R3/R5/R6/R8: every code combination; R4/R7: noise on every third frame
        for (int c = 0; c < (1 << (N*W)); c++)
            run_frame(c, (c % 3) == 0);
        frame_req = 1'b0;
        @(negedge clk);
        n_vec++;
        if (busy !== 1'b0) begin
            n_fail++;
            $display("FAIL R7 idle after last frame actual=%b expected=0", busy);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule